// File: doc/BRIEF.md
# GPIO Controller with Latched Edge Interrupts

This block is a small byte-addressed general-purpose I/O controller. It owns four output pins and four input pins. Software sets a direction mask, drives output levels, reads the synchronised input levels, and configures one interrupt per input pin. The output data register is write-only. A read at its offset returns zero, and the outputs come out of reset low.

Each input pin passes through a two-flop synchroniser. An edge detector compares the synchronised level with its value one cycle earlier. Every input keeps two sticky flags, one for rising edges and one for falling edges. Both flags latch whatever the configuration is. A 2-bit trigger field per input only chooses which of the two flags is visible in the status register and on the shared interrupt line. Writing a one to a status bit clears both flags of that input.

The register port is a plain single-cycle interface with no valid/ready handshake. A write takes effect at the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`. The port never stalls, so there is no back-pressure.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, `pin_out`, `pin_oe` and `irq_out` are 0, and reads at offsets 0 and 4 return 0x00.
- R2: Offset 0 is the direction register. Write bits [3:0] drive `pin_oe[3:0]` (1 = output enabled). A read returns those bits in [3:0] and zeros in [7:4].
- R3: Offset 1 is the output data register. Write bits [3:0] drive `pin_out[3:0]`. A read at offset 1 always returns 0x00. `pin_out` changes only after a write to offset 1.
- R4: Offset 2 reads the synchronised input levels in bits [3:0] and zeros in [7:4]. A pin change driven before clock edge k appears after edge k+1.
- R5: Offset 3 is the trigger configuration. Input n uses bits [2n+1:2n]. The codes are: 00 = nothing visible, 01 = falling flag visible, 10 = rising flag visible, 11 = nothing visible (not a both-edge mode).
- R6: The rising and falling flags of every input latch independently of its trigger code. An edge that arrives while the code is 00 becomes visible once the matching code is written later.
- R7: Offset 4 status bit n equals the flag selected for input n. Bits [7:4] read 0.
- R8: Writing 1 to status bit n clears both the rising and the falling flag of input n. Writing 0 leaves the flags unchanged.
- R9: If an edge is detected in the same cycle as a status clear for that input, the flag of the new edge ends up set.
- R10: `irq_out` is high exactly when at least one status bit reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 3 | Register offset for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_in | input | 4 | Asynchronous input pins |
| pin_out | output | 4 | Output pin levels |
| pin_oe | output | 4 | Output enables from the direction register |
| irq_out | output | 1 | Level interrupt request, high while any status bit is set |

## Verification
A flag that latches wrongly does not stay hidden. It shows up at offset 4 and on `irq_out` as soon as the matching trigger code is selected, even if the edge happened many cycles earlier. The bench therefore records edges under one code and reads them back under another. A clear that misses one of the two flags shows when the trigger code is switched after the clear. A lost collision between an edge and a clear shows as a zero status bit on the first read after that clock edge. Synchroniser latency errors show at offset 2 exactly one edge early or late.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DIR  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_OUT  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_IN   = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_TRIG = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_STS  = 3'd4;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_BAD  = 2'b11
  } trig_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] level,
  output logic [N-1:0] rise_ev,
  output logic [N-1:0] fall_ev
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1, s2, prev;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1   <= 1'b0;
        s2   <= 1'b0;
        prev <= 1'b0;
      end else begin
        s1   <= pin_in[i];
        s2   <= s1;
        prev <= s2;
      end
    end
    assign level[i]   = s2;
    assign rise_ev[i] = s2 & ~prev;
    assign fall_ev[i] = ~s2 & prev;
  end

  // R4
  in_sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 3) |-> level == $past(pin_in, 2));
endmodule

// File: rtl/gpio_edge_cell.sv
module gpio_edge_cell
  import gpio_edge_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise_ev,
  input  logic       fall_ev,
  input  logic       clr,
  input  logic [1:0] trig,
  output logic       visible
);
  logic rise_f, fall_f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_f <= 1'b0;
      fall_f <= 1'b0;
    end else begin
      rise_f <= rise_ev | (rise_f & ~clr);
      fall_f <= fall_ev | (fall_f & ~clr);
    end
  end

  always_comb begin
    unique case (trig_e'(trig))
      TRIG_FALL: visible = fall_f;
      TRIG_RISE: visible = rise_f;
      default:   visible = 1'b0;
    endcase
  end

  // R6
  rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> rise_f);
  // R9
  fall_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ev && clr) |=> fall_f);
  // R8
  clr_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !rise_ev && !fall_ev) |=> (!rise_f && !fall_f));
  // R5
  trig_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig == 2'b00 || trig == 2'b11) |-> !visible);
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_we,
  input  logic         out_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] out_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (dir_we) dir_q <= wdata;
      if (out_we) out_q <= wdata;
    end
  end

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(out_we) |-> $stable(out_q));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int unsigned N_OUT = 4,
  parameter int unsigned N_IN  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_IN-1:0]   pin_in,
  output logic [N_OUT-1:0]  pin_out,
  output logic [N_OUT-1:0]  pin_oe,
  output logic              irq_out
);
  localparam int unsigned TRIG_W = 2 * N_IN;

  logic [N_IN-1:0]   level, rise_ev, fall_ev, clr, sts;
  logic [TRIG_W-1:0] trig_q;
  logic              wr_trig;

  assign wr_trig = bus_we && (bus_addr == OFS_TRIG);

  gpio_port_regs #(.N(N_OUT)) u_port (
    .clk    (clk),
    .rst_n  (rst_n),
    .dir_we (bus_we && (bus_addr == OFS_DIR)),
    .out_we (bus_we && (bus_addr == OFS_OUT)),
    .wdata  (bus_wdata[N_OUT-1:0]),
    .dir_q  (pin_oe),
    .out_q  (pin_out)
  );

  gpio_in_sync #(.N(N_IN)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_in  (pin_in),
    .level   (level),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) trig_q <= '0;
    else if (wr_trig) trig_q <= bus_wdata[TRIG_W-1:0];
  end

  assign clr = (bus_we && (bus_addr == OFS_STS)) ? bus_wdata[N_IN-1:0] : '0;

  for (genvar n = 0; n < N_IN; n++) begin : g_cell
    gpio_edge_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise_ev (rise_ev[n]),
      .fall_ev (fall_ev[n]),
      .clr     (clr[n]),
      .trig    (trig_q[2*n+1:2*n]),
      .visible (sts[n])
    );
  end

  assign irq_out = |sts;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_DIR:  bus_rdata[N_OUT-1:0]  = pin_oe;
      OFS_IN:   bus_rdata[N_IN-1:0]   = level;
      OFS_TRIG: bus_rdata[TRIG_W-1:0] = trig_q;
      OFS_STS:  bus_rdata[N_IN-1:0]   = sts;
      default:  bus_rdata = '0;
    endcase
  end

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q == '0) |-> !irq_out);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !$past(rst_n) |-> (pin_out == '0 && pin_oe == '0 && !irq_out));
endmodule

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] pin_in = '0;
  logic [3:0] pin_out, pin_oe;
  logic       irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  gpio_edge_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  typedef struct packed {
    logic [3:0] pins;
    logic       we;
    logic [2:0] waddr;
    logic [7:0] wdata;
    logic [2:0] raddr;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'h0, 1'b1, 3'd0, 8'h0F, 3'd0, 8'h0F, 4'd2},  // R2 direction
    '{4'h0, 1'b1, 3'd0, 8'hFF, 3'd0, 8'h0F, 4'd2},  // R2 upper bits dropped
    '{4'h0, 1'b1, 3'd1, 8'h0A, 3'd1, 8'h00, 4'd3},  // R3 no readback
    '{4'h5, 1'b0, 3'd0, 8'h00, 3'd2, 8'h05, 4'd4},  // R4 input levels
    '{4'h5, 1'b0, 3'd0, 8'h00, 3'd4, 8'h00, 4'd5},  // R5 code 00
    '{4'h5, 1'b1, 3'd3, 8'hAA, 3'd4, 8'h05, 4'd6},  // R6 latched earlier
    '{4'h5, 1'b1, 3'd3, 8'h55, 3'd4, 8'h00, 4'd5},  // R5 falling view
    '{4'h0, 1'b0, 3'd0, 8'h00, 3'd4, 8'h05, 4'd5},  // R5 falls seen
    '{4'h0, 1'b1, 3'd4, 8'h01, 3'd4, 8'h04, 4'd8},  // R8 clear bit 0
    '{4'h0, 1'b1, 3'd3, 8'hAA, 3'd4, 8'h04, 4'd8},  // R8 rise flag also gone
    '{4'h0, 1'b1, 3'd3, 8'hFF, 3'd4, 8'h00, 4'd5},  // R5 code 11
    '{4'h0, 1'b1, 3'd4, 8'h0F, 3'd4, 8'h00, 4'd8},  // R8 clear all
    '{4'h0, 1'b1, 3'd3, 8'hAA, 3'd4, 8'h00, 4'd8},  // R8 nothing left
    '{4'h8, 1'b0, 3'd0, 8'h00, 3'd4, 8'h08, 4'd7}   // R7 single rise
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_we = 1'b0;
  endtask

  function automatic logic [7:0] rd(input logic [2:0] a);
    bus_addr = a;
    return 8'h00;
  endfunction

  task automatic rd_chk(input logic [2:0] a, input string tag, input logic [7:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 pin_out", {4'h0, pin_out}, 8'h00);
    check("R1 pin_oe", {4'h0, pin_oe}, 8'h00);
    check("R1 irq_out", {7'h0, irq_out}, 8'h00);
    rd_chk(3'd0, "R1 dir", 8'h00);
    rd_chk(3'd4, "R1 status", 8'h00);

    for (int i = 0; i < NV; i++) begin
      pin_in = VECS[i].pins;
      if (VECS[i].we) wr(VECS[i].waddr, VECS[i].wdata);
      else tick(1);
      tick(4);
      rd_chk(VECS[i].raddr, $sformatf("vector %0d req %0d", i, VECS[i].req), VECS[i].exp);
      if (VECS[i].raddr == 3'd4)
        check($sformatf("R10 irq vector %0d", i), {7'h0, irq_out}, {7'h0, |VECS[i].exp});
      if (i == 2) begin
        check("R3 pin_out", {4'h0, pin_out}, 8'h0A);
        check("R2 pin_oe", {4'h0, pin_oe}, 8'h0F);
      end
    end

    // R4 latency: change before edge k, new value after edge k+1
    pin_in = 4'h9;
    tick(1);
    rd_chk(3'd2, "R4 after one edge", 8'h08);
    tick(1);
    rd_chk(3'd2, "R4 after two edges", 8'h09);
    tick(3);

    // clear everything, rising view
    wr(3'd4, 8'h0F);
    tick(2);
    rd_chk(3'd4, "R8 cleared", 8'h00);
    check("R10 irq low", {7'h0, irq_out}, 8'h00);

    // R9 edge and clear in the same cycle
    pin_in = 4'hB;        // rise on input 1, before edge k
    tick(2);              // edges k and k+1 pass; rise event now present
    wr(3'd4, 8'h02);      // clear lands on edge k+2 with the event
    rd_chk(3'd4, "R9 edge beats clear", 8'h02);
    check("R10 irq high", {7'h0, irq_out}, 8'h01);
    wr(3'd4, 8'h02);
    rd_chk(3'd4, "R8 later clear", 8'h00);

    // R3 pin_out stays without write
    wr(3'd0, 8'h00);
    tick(2);
    check("R3 pin_out held", {4'h0, pin_out}, 8'h0A);
    check("R2 pin_oe off", {4'h0, pin_oe}, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule